// File: doc/BRIEF.md
# Serial Presence Detect Identification Store

This block is a two-wire (I2C) slave memory of 256 bytes that holds the identification data of a memory module. The system controller reads the module type, device characteristics and timing figures from it over SCL and SDA. The block oversamples both bus lines with the chip clock. It answers the 7-bit bus address made of the device-type nibble `1010` followed by three strap pins, so up to eight modules can share one bus.

The storage is a register file, and reset loads its defaults. The lower half (bytes 0 to 127) holds the factory identification contents. The upper half (bytes 128 to 255) is free space for the system. No write protection exists, so both halves accept writes. A single word pointer serves every access. A word-address byte loads it, and every data byte written or read advances it by one, wrapping from 255 to 0. The block supports single and multi-byte writes, current-address reads, sequential reads and random reads (a write of the word address followed by a repeated START).

The block drives SDA only through an open-drain pull-down enable. Clock stretching and nonvolatile write timing are not modelled.

Top module: `spd_eeprom_slave`

## Requirements
- R1: After reset `sda_oe_o` is 0. Byte i (i < 128) reads (i*37 + 90) mod 256, and byte i (i >= 128) reads 0xFF.
- R2: The block acknowledges an address byte only when its upper seven bits equal `1010` followed by `strap_i[2]`, `strap_i[1]`, `strap_i[0]` (the bus sends the MSB first, and bit 0 is R/W with 1 = read). Any other address gets no acknowledge, and the bytes that follow it until the next START change nothing.
- R3: In a write, the block acknowledges the word-address byte and every data byte by pulling SDA low during the ninth SCL pulse. It stores each data byte at the word pointer.
- R4: The word pointer advances by one after every data byte written or read, and wraps from 255 to 0.
- R5: A random read (address with R/W=0, word address, repeated START, address with R/W=1) returns data starting at the written word address.
- R6: A read with no word address continues from the current pointer. Each master acknowledge fetches the next byte. A master NACK on the ninth bit ends the read, and SDA stays released.
- R7: A START or STOP anywhere restarts bit counting. A data byte cut short by a STOP is not stored, and the pointer keeps its last value.
- R8: Writes succeed in both the identification half and the free half of the memory.
- R9: `sda_oe_o` changes only while SCL is low, except at a START or STOP, after which it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| strap_i | input | 3 | Address strap pins, low three bits of the bus address |
| sda_oe_o | output | 1 | 1 = pull SDA low (open-drain enable) |

## Verification
Each line passes through two synchronizer flops and one history flop before an edge is recognised, and the enable is registered on top of that. A response to an SCL falling edge therefore appears on `sda_oe_o` about four clocks after the edge. The bench holds every SCL phase for ten clocks and samples SDA at the middle of the high phase, well after that latency and before the next edge. Writes become visible only through later reads, and the bench compares each byte read against a model memory and a model pointer that it keeps itself.

// File: rtl/spd_pkg.sv
package spd_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WORD,
    ST_WORD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } spd_state_e;

  // factory contents of the identification half, erased value elsewhere
  function automatic logic [BYTE_W-1:0] spd_default(input int unsigned idx,
                                                     input int unsigned mfg_bytes);
    logic [31:0] v;
    v = idx * 32'd37 + 32'd90;
    return (idx < mfg_bytes) ? v[BYTE_W-1:0] : {BYTE_W{1'b1}};
  endfunction

endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic prev_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign prev_o  = prev_q;

endmodule

// File: rtl/spd_store.sv
module spd_store #(
  parameter int DEPTH     = 256,
  parameter int MFG_BYTES = 128,
  parameter int AW        = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [spd_pkg::BYTE_W-1:0] wr_data,
  input  logic [AW-1:0]             rd_addr,
  output logic [spd_pkg::BYTE_W-1:0] rd_data
);

  logic [spd_pkg::BYTE_W-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam logic [AW-1:0] IDX = AW'(i);
    localparam logic [spd_pkg::BYTE_W-1:0] INIT = spd_pkg::spd_default(i, MFG_BYTES);
    logic [spd_pkg::BYTE_W-1:0] cell_q;
    logic                       cell_we;

    assign cell_we = wr_en && (wr_addr == IDX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= INIT;
      end else if (cell_we) begin
        cell_q <= wr_data;
      end
    end

    assign cells[i] = cell_q;
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/spd_bus_fsm.sv
module spd_bus_fsm
  import spd_pkg::*;
#(
  parameter int          AW       = 8,
  parameter logic [3:0]  DEV_TYPE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              scl_p,
  input  logic              sda_s,
  input  logic              sda_p,
  input  logic [2:0]        strap,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic [AW-1:0]     ptr,
  output logic              sda_oe,
  output spd_state_e        st,
  output logic              start_det,
  output logic              stop_det
);

  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(BYTE_W);

  spd_state_e        st_q, st_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [BYTE_W-1:0] tx_q, tx_n;
  logic [AW-1:0]     ptr_q, ptr_n;
  logic              oe_q, oe_n;
  logic              rw_q, rw_n;
  logic              mack_q, mack_n;
  logic              scl_rise, scl_fall, rx_state, byte_done;

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign rx_state  = (st_q == ST_DEV) || (st_q == ST_WORD) || (st_q == ST_WDATA);
  assign byte_done = (cnt_q == CNT_FULL);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    tx_n   = tx_q;
    ptr_n  = ptr_q;
    oe_n   = oe_q;
    rw_n   = rw_q;
    mack_n = mack_q;
    wr_en  = 1'b0;
    if (start_det) begin
      st_n  = ST_DEV;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (stop_det) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (scl_rise) begin
      if (rx_state) begin
        sh_n  = {sh_q[BYTE_W-2:0], sda_s};
        cnt_n = cnt_q + 1'b1;
      end
      if (st_q == ST_RDATA)     cnt_n  = cnt_q + 1'b1;
      if (st_q == ST_RDATA_ACK) mack_n = ~sda_s;
    end else if (scl_fall) begin
      case (st_q)
        ST_DEV: if (byte_done) begin
          cnt_n = '0;
          if (sh_q[BYTE_W-1:1] == {DEV_TYPE, strap}) begin
            rw_n = sh_q[0];
            oe_n = 1'b1;
            st_n = ST_DEV_ACK;
          end else begin
            st_n = ST_IDLE;
          end
        end
        ST_DEV_ACK: begin
          if (rw_q) begin
            tx_n = rd_data;
            oe_n = ~rd_data[BYTE_W-1];
            st_n = ST_RDATA;
          end else begin
            oe_n = 1'b0;
            st_n = ST_WORD;
          end
        end
        ST_WORD: if (byte_done) begin
          ptr_n = sh_q[AW-1:0];
          oe_n  = 1'b1;
          cnt_n = '0;
          st_n  = ST_WORD_ACK;
        end
        ST_WORD_ACK: begin
          oe_n = 1'b0;
          st_n = ST_WDATA;
        end
        ST_WDATA: if (byte_done) begin
          wr_en = 1'b1;
          ptr_n = ptr_q + 1'b1;
          oe_n  = 1'b1;
          cnt_n = '0;
          st_n  = ST_WDATA_ACK;
        end
        ST_WDATA_ACK: begin
          oe_n = 1'b0;
          st_n = ST_WDATA;
        end
        ST_RDATA: begin
          if (byte_done) begin
            oe_n  = 1'b0;
            ptr_n = ptr_q + 1'b1;
            cnt_n = '0;
            st_n  = ST_RDATA_ACK;
          end else begin
            oe_n = ~tx_q[BYTE_W-2];
            tx_n = {tx_q[BYTE_W-2:0], 1'b1};
          end
        end
        ST_RDATA_ACK: begin
          if (mack_q) begin
            tx_n  = rd_data;
            oe_n  = ~rd_data[BYTE_W-1];
            cnt_n = '0;
            st_n  = ST_RDATA;
          end else begin
            st_n = ST_IDLE;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      oe_q   <= 1'b0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      tx_q   <= tx_n;
      ptr_q  <= ptr_n;
      oe_q   <= oe_n;
      rw_q   <= rw_n;
      mack_q <= mack_n;
    end
  end

  assign wr_data = sh_q;
  assign ptr     = ptr_q;
  assign sda_oe  = oe_q;
  assign st      = st_q;

endmodule

// File: rtl/spd_eeprom_slave.sv
module spd_eeprom_slave
  import spd_pkg::*;
#(
  parameter int         MEM_BYTES   = 256,
  parameter int         MFG_BYTES   = 128,
  parameter logic [3:0] DEV_TYPE    = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o
);

  localparam int AW    = $clog2(MEM_BYTES);
  localparam int LINES = 2;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [LINES-1:0]  raw, lvl, prv;
  logic              scl_lvl, scl_prv;
  logic              start_det, stop_det;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [AW-1:0]     ptr;
  spd_state_e        st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    spd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .line_i  (raw[g]),
      .level_o (lvl[g]),
      .prev_o  (prv[g])
    );
  end

  assign scl_lvl = lvl[0];
  assign scl_prv = prv[0];

  spd_bus_fsm #(.AW(AW), .DEV_TYPE(DEV_TYPE)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_s     (lvl[0]),
    .scl_p     (prv[0]),
    .sda_s     (lvl[1]),
    .sda_p     (prv[1]),
    .strap     (strap_i),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ptr       (ptr),
    .sda_oe    (sda_oe_o),
    .st        (st),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  spd_store #(.DEPTH(MEM_BYTES), .MFG_BYTES(MFG_BYTES), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (ptr),
    .wr_data (wr_data),
    .rd_addr (ptr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/spd_slave_chk.sv
module spd_slave_chk
  import spd_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          scl_p,
  input logic          start_det,
  input logic          stop_det,
  input logic          sda_oe,
  input logic [AW-1:0] ptr,
  input spd_state_e    st
);

  AST_EVENT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !sda_oe); // R7

  AST_OE_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_p && !$past(start_det || stop_det)) |-> $stable(sda_oe)); // R9

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> ((ptr == $past(ptr) + 1'b1) || ($past(st) == ST_WORD))); // R4

  AST_OE_ONLY_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st inside {ST_DEV_ACK, ST_WORD_ACK, ST_WDATA_ACK, ST_RDATA})); // R3

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe); // R2

endmodule

bind spd_eeprom_slave spd_slave_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .scl_s     (scl_lvl),
  .scl_p     (scl_prv),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe_o),
  .ptr       (ptr),
  .st        (st)
);

// File: tb/sim_spd_eeprom_slave.sv
`timescale 1ns/1ps
module sim_spd_eeprom_slave;

  localparam int H = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [2:0] strap = 3'd5;
  logic       sda_oe;
  wire        bus_sda = m_sda & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ptr = '0;
  bit   oe_glitch = 1'b0;
  logic oe_prev = 1'b0;

  always #10 clk = ~clk;

  spd_eeprom_slave u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (m_scl),
    .sda_i    (bus_sda),
    .strap_i  (strap),
    .sda_oe_o (sda_oe)
  );

  function automatic logic [7:0] reset_value(int i);
    if (i >= 128) return 8'hFF;
    return 8'((i * 37 + 90) % 256);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R9 monitor: enable may only move while SCL is low
  always @(negedge clk) begin
    if (rst_n && m_scl && (sda_oe != oe_prev)) oe_glitch = 1'b1;
    oe_prev = sda_oe;
  end

  task automatic bus_start();
    m_sda = 1'b1; wait_clk(H);
    m_scl = 1'b1; wait_clk(H);
    m_sda = 1'b0; wait_clk(H);
    m_scl = 1'b0; wait_clk(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clk(H);
    m_scl = 1'b1; wait_clk(H);
    m_sda = 1'b1; wait_clk(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      m_sda = b[i]; wait_clk(H);
      m_scl = 1'b1; wait_clk(H);
      m_scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    m_sda = 1'b1; wait_clk(H);
    m_scl = 1'b1; wait_clk(H / 2);
    acked = !bus_sda; wait_clk(H / 2);
    m_scl = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wait_clk(H);
      m_scl = 1'b1; wait_clk(H / 2);
      b[i] = bus_sda; wait_clk(H / 2);
      m_scl = 1'b0;
    end
    m_sda = give_ack ? 1'b0 : 1'b1; wait_clk(H);
    m_scl = 1'b1; wait_clk(H);
    m_scl = 1'b0;
  endtask

  function automatic logic [7:0] dev_byte(input logic [2:0] s, input bit rd);
    return {4'b1010, s, rd};
  endfunction

  task automatic do_write(input logic [7:0] addr, input int len, input string req);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte(dev_byte(strap, 1'b0), a); check(a, "R2", a, 1);
    send_byte(addr, a);                  check(a, "R3", a, 1);
    exp_ptr = addr;
    for (int k = 0; k < len; k++) begin
      d = 8'($urandom);
      send_byte(d, a); check(a, req, a, 1);
      exp_mem[exp_ptr] = d;
      exp_ptr = exp_ptr + 8'd1;
    end
    bus_stop();
  endtask

  task automatic read_tail(input int len, input string req);
    logic [7:0] d;
    for (int k = 0; k < len; k++) begin
      recv_byte(k != len - 1, d);
      check(d == exp_mem[exp_ptr], req, d, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + 8'd1;
    end
    bus_stop();
  endtask

  task automatic do_rand_read(input logic [7:0] addr, input int len, input string req);
    bit a;
    bus_start();
    send_byte(dev_byte(strap, 1'b0), a); check(a, "R2", a, 1);
    send_byte(addr, a);                  check(a, "R3", a, 1);
    exp_ptr = addr;
    bus_start();
    send_byte(dev_byte(strap, 1'b1), a); check(a, "R2", a, 1);
    read_tail(len, req);
  endtask

  task automatic do_cur_read(input int len, input string req);
    bit a;
    bus_start();
    send_byte(dev_byte(strap, 1'b1), a); check(a, "R2", a, 1);
    read_tail(len, req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    bit a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) exp_mem[i] = reset_value(i);
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1: released bus and reset contents in both halves
    check(sda_oe == 1'b0, "R1", sda_oe, 0);
    do_rand_read(8'd0, 4, "R1");
    do_rand_read(8'd126, 4, "R1");
    do_rand_read(8'd250, 2, "R1");

    // R2: foreign strap and foreign type are ignored, no effect on memory
    bus_start();
    send_byte(dev_byte(3'd2, 1'b0), a); check(!a, "R2", a, 0);
    send_byte(8'h10, a);
    send_byte(8'h55, a);
    bus_stop();
    bus_start();
    send_byte({4'b1011, strap, 1'b0}, a); check(!a, "R2", a, 0);
    bus_stop();
    do_rand_read(8'h10, 1, "R2");

    // R8: writes land in both halves
    do_write(8'd127, 2, "R8");
    do_rand_read(8'd127, 2, "R8");

    // R4: pointer wrap on write and on read
    do_write(8'd254, 3, "R4");
    do_rand_read(8'd253, 5, "R4");

    // R7: STOP in the middle of a data byte stores nothing
    bus_start();
    send_byte(dev_byte(strap, 1'b0), a); check(a, "R2", a, 1);
    send_byte(8'h40, a);                 check(a, "R3", a, 1);
    send_bits(8'h00, 4);
    bus_stop();
    exp_ptr = 8'h40;
    // R6: current-address read continues from the pointer, NACK releases SDA
    do_cur_read(2, "R7");
    wait_clk(H);
    check(sda_oe == 1'b0, "R6", sda_oe, 0);

    // R5/R6 constrained random traffic with strap changes
    for (int t = 0; t < 30; t++) begin
      int op;
      strap = 3'($urandom);
      op = $urandom_range(0, 2);
      if (op == 0)      do_write(8'($urandom), $urandom_range(1, 4), "R3");
      else if (op == 1) do_rand_read(8'($urandom), $urandom_range(1, 4), "R5");
      else              do_cur_read($urandom_range(1, 3), "R6");
    end

    check(!oe_glitch, "R9", oe_glitch, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule